// File: doc/BRIEF.md
# Pilot-Tone Frequency Offset Tracker

This block follows the frequency offset between the far-end sample clock and the local sample clock. It does this from a phase-error value measured on a pilot tone, and it receives one such value for each received symbol. Each value passes through a second-order loop with a proportional and an integral branch. The integral branch holds the running frequency-offset estimate. The loop output adds into an accumulated phase.

The block corrects in two tiers. While the accumulated phase is small, its upper bits go out every symbol as a rotation angle. A frequency-domain rotator uses that angle to turn the received constellation back. When the accumulated phase grows past a programmable bound, the block issues a one-cycle insert or delete command to the sample input sequence. It then moves the phase back by the programmed phase of one sample period.

A small register port sets the gains, the slip bound, the slip step and the lock threshold. The same port reads back the offset estimate and the accumulated phase. A lock flag reports a sustained run of small errors.

Top module: `pilot_offset_tracker`

## Requirements
- R1: A synchronous active-high reset clears the integrator, the accumulated phase, the rotation angle, the valid and slip outputs and the lock flag. It also returns all configuration fields to their default values.
- R2: On each symbol strobe, the error is widened to 32 bits by appending 16 zero bits (e·2^16). The integrator becomes the saturating sum of its old value and that widened error shifted right arithmetically by the integral shift. The integrator value is readable at address 4.
- R3: The accumulated phase becomes sat(sat(phase + new integrator) + widened error >>> proportional shift). Every sum clamps at 0x7FFFFFFF and 0x80000000.
- R4: The cycle after a symbol strobe, rot_valid is high for one cycle. rot_angle then equals bits 31:16 of the accumulated phase after any slip, in two's complement, where 0x8000 stands for -pi.
- R5: If the phase from R3 is greater than the slip bound, slip_valid and slip_insert are high with rot_valid. The stored phase is the R3 phase minus the slip step.
- R6: If the phase from R3 is less than the negated slip bound, slip_valid is high and slip_insert is low. The stored phase is the R3 phase plus the slip step.
- R7: At most one slip is issued per symbol. A phase inside the bound, the bound itself included, issues none and is stored unchanged.
- R8: A symbol counts as good when its error magnitude is strictly below the lock threshold. locked is high once LOCK_RUN consecutive symbols have been good, and goes low in the cycle after a symbol that is not good.
- R9: The configuration port uses these addresses. Address 0 holds the proportional shift in bits 4:0 and the integral shift in bits 12:8. Address 1 holds the slip bound in bits 30:0. Address 2 holds the slip step in bits 30:0. Address 3 holds the lock threshold in bits 15:0. Addresses 4 and 5 are read-only and return the integrator and the phase. Unused bits read as zero.
- R10: Without a symbol strobe, the integrator, the phase, the rotation angle and the lock state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle strobe per symbol |
| err_phase | input | 16 | Signed pilot phase error, 0x8000 = -pi |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| rot_valid | output | 1 | New rotation angle present |
| rot_angle | output | 16 | Constellation rotation angle |
| slip_valid | output | 1 | Sample slip command |
| slip_insert | output | 1 | 1 = insert a cycle, 0 = delete a cycle |
| locked | output | 1 | Lock flag |

## Verification
The bench builds the block with LOCK_RUN set to 8 and keeps every other default. The lock flag therefore rises after eight good symbols, and the bench can hit the exact rise edge, the threshold-equal case and the drop within a short run. The bench then programs zero proportional and integral shifts. That turns every symbol into a quarter- to half-turn phase step, so both slip directions and saturation of both accumulators happen within a few symbols. A reset in the middle of the run confirms that the default configuration comes back.

// File: rtl/pot_pkg.sv
package pot_pkg;

    localparam int ACC_W      = 32;
    localparam int ERR_W      = 16;
    localparam int ROT_W      = 16;
    localparam int SHIFT_W    = 5;
    localparam int ADDR_W     = 3;
    localparam int GAIN_KI_LSB = 8;
    localparam int TH_W       = ACC_W - 1;

    typedef struct packed {
        logic [SHIFT_W-1:0] kp_sh;
        logic [SHIFT_W-1:0] ki_sh;
        logic [TH_W-1:0]    slip_th;
        logic [TH_W-1:0]    slip_step;
        logic [ERR_W-1:0]   lock_th;
    } pot_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        A_GAIN  = 3'd0,
        A_SLIPB = 3'd1,
        A_STEP  = 3'd2,
        A_LOCKT = 3'd3,
        A_FREQ  = 3'd4,
        A_PHASE = 3'd5
    } pot_addr_e;

    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_INS  = 2'd1,
        SLIP_DEL  = 2'd2
    } pot_slip_e;

endpackage

// File: rtl/pot_sat_add.sv
module pot_sat_add #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide = {a[W-1], a} + {b[W-1], b};
        if (wide[W] != wide[W-1])
            y = wide[W] ? MINV : MAXV;
        else
            y = wide[W-1:0];
    end
endmodule

// File: rtl/pot_cfg_regs.sv
module pot_cfg_regs
    import pot_pkg::*;
#(
    parameter int KP_SHIFT_RST = 4,
    parameter int KI_SHIFT_RST = 10,
    parameter logic [ACC_W-1:0] SLIP_TH_RST   = 32'h2000_0000,
    parameter logic [ACC_W-1:0] SLIP_STEP_RST = 32'h0080_0000,
    parameter logic [ERR_W-1:0] LOCK_TH_RST   = 16'd512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ACC_W-1:0]  wdata,
    input  logic [ACC_W-1:0]  integ,
    input  logic [ACC_W-1:0]  phase,
    output logic [ACC_W-1:0]  rdata,
    output pot_cfg_t          cfg
);
    logic wdata_unused;
    assign wdata_unused = wdata[ACC_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.kp_sh     <= SHIFT_W'(KP_SHIFT_RST);
            cfg.ki_sh     <= SHIFT_W'(KI_SHIFT_RST);
            cfg.slip_th   <= SLIP_TH_RST[TH_W-1:0];
            cfg.slip_step <= SLIP_STEP_RST[TH_W-1:0];
            cfg.lock_th   <= LOCK_TH_RST;
        end else if (we) begin
            case (pot_addr_e'(addr))
                A_GAIN: begin
                    cfg.kp_sh <= wdata[SHIFT_W-1:0];
                    cfg.ki_sh <= wdata[GAIN_KI_LSB +: SHIFT_W];
                end
                A_SLIPB: cfg.slip_th   <= wdata[TH_W-1:0];
                A_STEP:  cfg.slip_step <= wdata[TH_W-1:0];
                A_LOCKT: cfg.lock_th   <= wdata[ERR_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (pot_addr_e'(addr))
            A_GAIN: begin
                rdata[SHIFT_W-1:0]              = cfg.kp_sh;
                rdata[GAIN_KI_LSB +: SHIFT_W]   = cfg.ki_sh;
            end
            A_SLIPB: rdata[TH_W-1:0]  = cfg.slip_th;
            A_STEP:  rdata[TH_W-1:0]  = cfg.slip_step;
            A_LOCKT: rdata[ERR_W-1:0] = cfg.lock_th;
            A_FREQ:  rdata = integ;
            A_PHASE: rdata = phase;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pot_loop_filter.sv
module pot_loop_filter
    import pot_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sym_valid,
    input  logic signed [ERR_W-1:0] sym_err,
    input  logic [SHIFT_W-1:0]      kp_sh,
    input  logic [SHIFT_W-1:0]      ki_sh,
    input  logic [TH_W-1:0]         slip_th,
    input  logic [TH_W-1:0]         slip_step,
    output logic signed [ACC_W-1:0] integ_q,
    output logic signed [ACC_W-1:0] phase_q,
    output logic [ROT_W-1:0]        rot_angle,
    output logic                    rot_valid,
    output logic                    slip_valid,
    output logic                    slip_insert
);
    localparam int PAD_W = ACC_W - ERR_W;

    logic signed [ACC_W-1:0] err_wide;
    logic signed [ACC_W-1:0] p_term;
    logic signed [ACC_W-1:0] i_term;
    logic signed [ACC_W-1:0] integ_nx;
    logic signed [ACC_W-1:0] ph_a;
    logic signed [ACC_W-1:0] ph_b;
    logic signed [ACC_W-1:0] ph_c;
    logic signed [ACC_W-1:0] bound_hi;
    logic signed [ACC_W-1:0] bound_lo;
    logic signed [ACC_W-1:0] step_s;
    pot_slip_e               slip_sel;

    assign err_wide = {sym_err, {PAD_W{1'b0}}};
    assign p_term   = err_wide >>> kp_sh;
    assign i_term   = err_wide >>> ki_sh;

    pot_sat_add #(.W(ACC_W)) u_add_integ (.a(integ_q), .b(i_term),   .y(integ_nx));
    pot_sat_add #(.W(ACC_W)) u_add_freq  (.a(phase_q), .b(integ_nx), .y(ph_a));
    pot_sat_add #(.W(ACC_W)) u_add_prop  (.a(ph_a),    .b(p_term),   .y(ph_b));

    assign bound_hi = {1'b0, slip_th};
    assign bound_lo = -bound_hi;
    assign step_s   = {1'b0, slip_step};

    always_comb begin
        if (ph_b > bound_hi) begin
            slip_sel = SLIP_INS;
            ph_c     = ph_b - step_s;
        end else if (ph_b < bound_lo) begin
            slip_sel = SLIP_DEL;
            ph_c     = ph_b + step_s;
        end else begin
            slip_sel = SLIP_NONE;
            ph_c     = ph_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q     <= '0;
            phase_q     <= '0;
            rot_valid   <= 1'b0;
            slip_valid  <= 1'b0;
            slip_insert <= 1'b0;
        end else begin
            rot_valid   <= sym_valid;
            slip_valid  <= sym_valid && (slip_sel != SLIP_NONE);
            slip_insert <= sym_valid && (slip_sel == SLIP_INS);
            if (sym_valid) begin
                integ_q <= integ_nx;
                phase_q <= ph_c;
            end
        end
    end

    assign rot_angle = phase_q[ACC_W-1 -: ROT_W];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (integ_q == '0 && phase_q == '0 && !rot_valid && !slip_valid && !slip_insert));

    // R4
    valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
        rot_valid |-> $past(sym_valid));

    // R2
    integ_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !i_term[ACC_W-1]) |=> (integ_q >= $past(integ_q)));

    // R7
    no_slip_inside_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && ph_b <= bound_hi && ph_b >= bound_lo) |=> (!slip_valid && !slip_insert));

    // R5
    insert_needs_slip_chk: assert property (@(posedge clk) disable iff (rst)
        slip_insert |-> (slip_valid && rot_valid));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ($stable(integ_q) && $stable(phase_q)));
endmodule

// File: rtl/pot_lock_detect.sv
module pot_lock_detect
    import pot_pkg::*;
#(
    parameter int LOCK_RUN = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sym_valid,
    input  logic signed [ERR_W-1:0] sym_err,
    input  logic [ERR_W-1:0]        lock_th,
    output logic                    locked
);
    localparam int CNT_W = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_C = CNT_W'(LOCK_RUN);

    logic signed [ERR_W:0] err_ext;
    logic [ERR_W:0]        err_mag;
    logic                  good;
    logic [CNT_W-1:0]      run_q;

    assign err_ext = {sym_err[ERR_W-1], sym_err};
    assign err_mag = err_ext[ERR_W] ? (~err_ext + 1'b1) : err_ext;
    assign good    = err_mag < {1'b0, lock_th};

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (sym_valid) begin
            if (!good)
                run_q <= '0;
            else if (run_q != RUN_C)
                run_q <= run_q + 1'b1;
        end
    end

    assign locked = (run_q == RUN_C);

    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !good) |=> !locked);

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(sym_valid && good));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(locked));
endmodule

// File: rtl/pilot_offset_tracker.sv
module pilot_offset_tracker
    import pot_pkg::*;
#(
    parameter int LOCK_RUN     = 64,
    parameter int KP_SHIFT_RST = 4,
    parameter int KI_SHIFT_RST = 10,
    parameter logic [31:0] SLIP_TH_RST   = 32'h2000_0000,
    parameter logic [31:0] SLIP_STEP_RST = 32'h0080_0000,
    parameter logic [15:0] LOCK_TH_RST   = 16'd512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        err_valid,
    input  logic [15:0] err_phase,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        rot_valid,
    output logic [15:0] rot_angle,
    output logic        slip_valid,
    output logic        slip_insert,
    output logic        locked
);
    pot_cfg_t                cfg;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] phase_q;
    logic signed [ERR_W-1:0] err_s;

    assign err_s = err_phase;

    pot_cfg_regs #(
        .KP_SHIFT_RST (KP_SHIFT_RST),
        .KI_SHIFT_RST (KI_SHIFT_RST),
        .SLIP_TH_RST  (SLIP_TH_RST),
        .SLIP_STEP_RST(SLIP_STEP_RST),
        .LOCK_TH_RST  (LOCK_TH_RST)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .integ(integ_q),
        .phase(phase_q),
        .rdata(cfg_rdata),
        .cfg  (cfg)
    );

    pot_loop_filter u_loop (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (err_valid),
        .sym_err    (err_s),
        .kp_sh      (cfg.kp_sh),
        .ki_sh      (cfg.ki_sh),
        .slip_th    (cfg.slip_th),
        .slip_step  (cfg.slip_step),
        .integ_q    (integ_q),
        .phase_q    (phase_q),
        .rot_angle  (rot_angle),
        .rot_valid  (rot_valid),
        .slip_valid (slip_valid),
        .slip_insert(slip_insert)
    );

    pot_lock_detect #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .sym_valid(err_valid),
        .sym_err  (err_s),
        .lock_th  (cfg.lock_th),
        .locked   (locked)
    );
endmodule

// File: tb/test_pilot_offset_tracker.sv
module test_pilot_offset_tracker;
    localparam int RUN = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_valid = 1'b0;
    logic [15:0] err_phase = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rot_valid;
    logic [15:0] rot_angle;
    logic        slip_valid;
    logic        slip_insert;
    logic        locked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] rot;
        bit          sv;
        bit          si;
        bit          lk;
    } exp_t;
    exp_t exp_q[$];

    longint m_integ, m_phase, m_th, m_step;
    int m_kp, m_ki, m_lockth, m_cnt;

    pilot_offset_tracker #(.LOCK_RUN(RUN)) i_pilot_offset_tracker (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_phase(err_phase),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rot_valid(rot_valid), .rot_angle(rot_angle), .slip_valid(slip_valid),
        .slip_insert(slip_insert), .locked(locked)
    );

    always #10 clk = ~clk;

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_defaults();
        m_integ = 0; m_phase = 0; m_cnt = 0;
        m_kp = 4; m_ki = 10; m_th = 64'h2000_0000; m_step = 64'h0080_0000; m_lockth = 512;
    endtask

    // driver: model per R2..R8, push expectation, drive one symbol
    task automatic send(input int e);
        longint ex, pb;
        exp_t x;
        int mag;
        ex = longint'(e) * 65536;
        m_integ = sat32(m_integ + (ex >>> m_ki));
        pb = sat32(sat32(m_phase + m_integ) + (ex >>> m_kp));
        x.sv = 0; x.si = 0;
        if (pb > m_th) begin x.sv = 1; x.si = 1; pb = pb - m_step; end
        else if (pb < -m_th) begin x.sv = 1; pb = pb + m_step; end
        m_phase = pb;
        mag = (e < 0) ? -e : e;
        if (mag < m_lockth) m_cnt = (m_cnt == RUN) ? RUN : m_cnt + 1;
        else m_cnt = 0;
        x.lk = (m_cnt == RUN);
        x.rot = m_phase[31:16];
        exp_q.push_back(x);
        err_valid = 1'b1;
        err_phase = 16'(e);
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            3'd0: begin m_kp = int'(d[4:0]); m_ki = int'(d[12:8]); end
            3'd1: m_th = longint'(d[30:0]);
            3'd2: m_step = longint'(d[30:0]);
            3'd3: m_lockth = int'(d[15:0]);
            default: ;
        endcase
    endtask

    task automatic cfg_read(input string req, input logic [2:0] a, input logic [31:0] expv);
        cfg_addr = a;
        #1;
        check(req, longint'(cfg_rdata), longint'(expv));
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (!rst && rot_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R4 actual=unexpected_valid expected=none");
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check("R4 rot_angle", longint'(rot_angle), longint'(x.rot));
                if (x.si) check("R5 slip", longint'({slip_valid, slip_insert}), 64'd3);
                else if (x.sv) check("R6 slip", longint'({slip_valid, slip_insert}), 64'd2);
                else check("R7 no slip", longint'({slip_valid, slip_insert}), 64'd0);
                check("R8 locked", longint'(locked), longint'(x.lk));
            end
        end else if (!rst && slip_valid) begin
            checks++; failures++;
            $display("FAIL R7 actual=slip_without_valid expected=none");
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_defaults();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rot_angle", longint'(rot_angle), 0);
        check("R1 locked", longint'(locked), 0);
        check("R1 rot_valid", longint'(rot_valid), 0);
        cfg_read("R9 gain default", 3'd0, 32'h0000_0A04);
        cfg_read("R9 lock default", 3'd3, 32'd512);
        cfg_read("R2 freq reset", 3'd4, 32'd0);

        // R2 R3 R4 small alternating errors, default gains
        for (int i = 0; i < 20; i++) send(((i % 2) ? -1 : 1) * (150 + 53 * i));
        for (int i = 0; i < 6; i++) send(400 - 25 * i);
        @(negedge clk);
        cfg_read("R2 freq readback", 3'd4, 32'(m_integ));
        cfg_read("R9 phase readback", 3'd5, 32'(m_phase));

        // R10 no strobe: hold
        repeat (5) @(negedge clk);
        check("R10 rot hold", longint'(rot_angle), longint'(m_phase[31:16]));
        cfg_read("R10 freq hold", 3'd4, 32'(m_integ));
        check("R10 lock hold", longint'(locked), longint'(m_cnt == RUN));

        // R8 lock run with boundary magnitudes
        cfg_write(3'd3, 32'd300);
        cfg_read("R9 lock write", 3'd3, 32'd300);
        for (int i = 0; i < RUN + 2; i++) send((i % 2) ? -299 : 120);
        send(300);
        send(-50);
        for (int i = 0; i < RUN; i++) send(-299);
        send(-300);

        // R5 R6 R7 slips with fast gains
        cfg_write(3'd0, 32'h0000_0602);
        cfg_write(3'd1, 32'h1000_0000);
        cfg_write(3'd2, 32'h0400_0000);
        cfg_read("R9 gain write", 3'd0, 32'h0000_0602);
        cfg_read("R9 step write", 3'd2, 32'h0400_0000);
        for (int i = 0; i < 10; i++) send(8000);
        for (int i = 0; i < 24; i++) send(-8000);

        // R2 R3 saturation with zero shifts
        cfg_write(3'd0, 32'h0000_0000);
        for (int i = 0; i < 5; i++) send(32767);
        @(negedge clk);
        cfg_read("R2 integ saturate hi", 3'd4, 32'h7FFF_FFFF);
        for (int i = 0; i < 8; i++) send(-32768);
        @(negedge clk);
        cfg_read("R2 freq after neg", 3'd4, 32'(m_integ));
        cfg_read("R3 phase", 3'd5, 32'(m_phase));

        // R1 mid-run reset restores defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_defaults();
        check("R1 rot cleared", longint'(rot_angle), 0);
        check("R1 lock cleared", longint'(locked), 0);
        cfg_read("R1 freq cleared", 3'd4, 32'd0);
        cfg_read("R1 gain default", 3'd0, 32'h0000_0A04);
        cfg_read("R1 slip bound default", 3'd1, 32'h2000_0000);
        for (int i = 0; i < 4; i++) send(1000 - 300 * i);
        repeat (3) @(negedge clk);
        check("R4 queue drained", longint'(exp_q.size()), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule